// File: doc/BRIEF.md
# Serial Pattern-Unlock Access Controller

This block sits in the chip-enable path of an external memory and observes the bus strobes. It watches the chip-enable input, the output enable and the write enable. Normal memory traffic passes through, with the gated chip-enable following the input. Hidden inside that traffic, a run of 64 write cycles can carry a fixed bit-serial key on the data-in line. When the key has matched completely, the block opens a window of 64 bus cycles. During the window the memory is held deselected, and each cycle moves one bit between the bus and a 64-bit image of eight byte-wide clock registers. The window takes no address space.

Strobes are synchronised to the system clock. A bus cycle counts when the chip-enable input deasserts. A read copies out a snapshot of the live register image, taken at the moment of unlock. Written bits collect in a shadow copy, and that copy is handed to the clock counters as one 64-bit word, but only when all 64 window cycles were writes. A digital power-fail input and a reset input, which can be masked, both abort a window without touching the registers.

Top module: `keyed_access_ctrl`

## Requirements
- R1: After reset the block is locked with the key pointer at 0, `mem_cs_n_o` follows `cs_n_i`, and `commit_o` and `dout_o` are 0.
- R2: Key bit i is bit (i mod 8) of byte (i div 8) of the byte list C5, 3A, A3, 5C, C5, 3A, A3, 5C, so each byte goes least-significant bit first. Each write cycle compares `din_i` with the key bit at the pointer. A match advances the pointer, and a match at bit 63 opens the window.
- R3: A mismatching write freezes recognition. Every later write is ignored until a read cycle occurs.
- R4: A read cycle outside the window returns the key pointer to bit 0 and clears a frozen state.
- R5: A bus cycle ends when `cs_n_i` rises. It is a write if `we_n_i` was low just before that edge, a read if only `oe_n_i` was low, and it is ignored if neither was low.
- R6: The window spans exactly 64 bus cycles, and cycle k moves image bit k, which is bit k mod 8 of register k div 8. Reads drive `dout_o` with bit k of the `time_img_i` value captured at unlock. Outside the window `dout_o` is 0.
- R7: Outside the window and without power-fail, `mem_cs_n_o` equals `cs_n_i`. Inside the window it is held at 1.
- R8: At window close, if all 64 cycles were writes, `commit_o` pulses for one clock with `commit_data_o` carrying the written bits. Otherwise no commit occurs. `commit_o` never pulses at any other time.
- R9: While `pwr_fail_i` is 1, an open window or partial key is discarded with no commit, and bus cycles are ignored.
- R10: While `pwr_fail_i` is 1, `mem_cs_n_o` is 1 when `rom_mode_i` is 0 and 0 when `rom_mode_i` is 1.
- R11: When image bit 36 (register 4, bit 4) of `time_img_i` is 0, a low `ext_rst_n_i` discards any window or partial key with no commit. When that bit is 1, `ext_rst_n_i` has no effect.
- R12: After a window closes, the block is locked again with the key pointer at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip-enable input from the bus, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| din_i | input | 1 | Serial data-in bit |
| pwr_fail_i | input | 1 | Digital power-fail indication |
| rom_mode_i | input | 1 | 1 selects ROM behaviour for the gated enable on power-fail |
| ext_rst_n_i | input | 1 | Transfer-abort input, active low, maskable |
| time_img_i | input | 64 | Live image of the eight clock registers |
| mem_cs_n_o | output | 1 | Gated chip-enable to the memory |
| dout_o | output | 1 | Serial data-out bit during window reads |
| commit_o | output | 1 | One-clock pulse that commits written data |
| commit_data_o | output | 64 | Written register image, valid with `commit_o` |

## Verification
The bound checker watches the following properties on every clock:
- the memory is held deselected whenever a window is open;
- the gated enable is forced to the correct level for the mode under power-fail;
- power-fail closes any window;
- a commit happens only on the clock where a window closes;
- a read before unlock clears the pointer and the frozen state;
- a frozen state stays frozen across writes;
- a window opens only from a write cycle.

Other behaviour only shows up in the bench's scenarios. These include the exact key contents and their bit order, the count of 64 cycles per window, the bit-to-register mapping on reads and commits, the ignored strobe-less cycle, and the way the reset mask bit is read from the live image. The bench's reference model checks them against the outputs on every settled clock.

// File: rtl/kac_pkg.sv
package kac_pkg;

    // Unlock key: byte n occupies bits [8n+7:8n], each byte consumed LSB first
    localparam logic [63:0] KAC_KEY = 64'h5CA33AC5_5CA33AC5;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_DEAD = 2'd1,
        ST_XFER = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic dat;
    } bus_evt_t;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic din;
    } strobe_t;

endpackage

// File: rtl/kac_sync.sv
module kac_sync #(
    parameter int unsigned    W       = 4,
    parameter int unsigned    STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], d_i[b]};
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                chain_q <= {STAGES{RST_VAL[b]}};
            end else begin
                chain_q <= chain_d;
            end
        end

        assign q_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/kac_cycle_det.sv
module kac_cycle_det
    import kac_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  strobe_t  strb_i,
    output bus_evt_t evt_o
);

    strobe_t prev_d, prev_q;

    always_comb begin
        prev_d = strb_i;
        evt_o  = '0;
        // cycle completes when chip enable goes from low to high
        if (strb_i.cs_n && !prev_q.cs_n) begin
            evt_o.wr = !prev_q.we_n;
            evt_o.rd = prev_q.we_n && !prev_q.oe_n;
        end
        evt_o.dat = prev_q.din;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, din: 1'b0};
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/kac_seq.sv
module kac_seq
    import kac_pkg::*;
#(
    parameter int unsigned       KEY_W      = 64,
    parameter int unsigned       XFER_W     = 64,
    parameter logic [KEY_W-1:0]  KEY        = KAC_KEY[KEY_W-1:0],
    parameter int unsigned       RST_EN_BIT = 36,
    localparam int unsigned      KPW        = $clog2(KEY_W),
    localparam int unsigned      XPW        = $clog2(XFER_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  bus_evt_t          evt_i,
    input  logic              pwr_fail_i,
    input  logic              ext_rst_n_i,
    input  logic [XFER_W-1:0] time_img_i,
    output logic              xfer_active_o,
    output logic              dout_o,
    output logic              commit_o,
    output logic [XFER_W-1:0] commit_data_o,
    output logic [KPW-1:0]    key_ptr_o,
    output logic              dead_o
);

    localparam logic [KPW-1:0] KPTR_LAST = KPW'(KEY_W - 1);
    localparam logic [XPW-1:0] XPTR_LAST = XPW'(XFER_W - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [KPW-1:0]    kptr;
        logic [XPW-1:0]    xptr;
        logic [XFER_W-1:0] shadow;
        logic              all_wr;
        logic              commit;
    } seq_t;

    seq_t s_d, s_q;
    logic abort;

    always_comb begin
        s_d        = s_q;
        s_d.commit = 1'b0;
        abort      = pwr_fail_i || (!time_img_i[RST_EN_BIT] && !ext_rst_n_i);

        if (abort) begin
            s_d.st     = ST_HUNT;
            s_d.kptr   = '0;
            s_d.xptr   = '0;
            s_d.all_wr = 1'b0;
        end else if (evt_i.rd || evt_i.wr) begin
            unique case (s_q.st)
                ST_HUNT: begin
                    if (evt_i.rd) begin
                        s_d.kptr = '0;
                    end else if (evt_i.dat == KEY[s_q.kptr]) begin
                        if (s_q.kptr == KPTR_LAST) begin
                            s_d.st     = ST_XFER;
                            s_d.kptr   = '0;
                            s_d.xptr   = '0;
                            s_d.shadow = time_img_i;
                            s_d.all_wr = 1'b1;
                        end else begin
                            s_d.kptr = s_q.kptr + 1'b1;
                        end
                    end else begin
                        s_d.st = ST_DEAD;
                    end
                end
                ST_DEAD: begin
                    if (evt_i.rd) begin
                        s_d.st   = ST_HUNT;
                        s_d.kptr = '0;
                    end
                end
                ST_XFER: begin
                    if (evt_i.wr) begin
                        s_d.shadow[s_q.xptr] = evt_i.dat;
                    end else begin
                        s_d.all_wr = 1'b0;
                    end
                    if (s_q.xptr == XPTR_LAST) begin
                        s_d.st     = ST_HUNT;
                        s_d.kptr   = '0;
                        s_d.xptr   = '0;
                        s_d.commit = s_q.all_wr && evt_i.wr;
                        s_d.all_wr = 1'b0;
                    end else begin
                        s_d.xptr = s_q.xptr + 1'b1;
                    end
                end
                default: begin
                    s_d.st   = ST_HUNT;
                    s_d.kptr = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{st: ST_HUNT, kptr: '0, xptr: '0, shadow: '0,
                     all_wr: 1'b0, commit: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign xfer_active_o = (s_q.st == ST_XFER);
    assign dout_o        = xfer_active_o ? s_q.shadow[s_q.xptr] : 1'b0;
    assign commit_o      = s_q.commit;
    assign commit_data_o = s_q.shadow;
    assign key_ptr_o     = s_q.kptr;
    assign dead_o        = (s_q.st == ST_DEAD);

endmodule

// File: rtl/keyed_access_ctrl.sv
module keyed_access_ctrl
    import kac_pkg::*;
#(
    parameter int unsigned      KEY_W       = 64,
    parameter int unsigned      XFER_W      = 64,
    parameter logic [KEY_W-1:0] KEY         = KAC_KEY[KEY_W-1:0],
    parameter int unsigned      RST_EN_BIT  = 36,
    parameter int unsigned      SYNC_STAGES = 2,
    localparam int unsigned     KPW         = $clog2(KEY_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic              din_i,
    input  logic              pwr_fail_i,
    input  logic              rom_mode_i,
    input  logic              ext_rst_n_i,
    input  logic [XFER_W-1:0] time_img_i,
    output logic              mem_cs_n_o,
    output logic              dout_o,
    output logic              commit_o,
    output logic [XFER_W-1:0] commit_data_o
);

    strobe_t        strb_raw, strb_sync;
    bus_evt_t       evt;
    logic           xfer_active;
    logic [KPW-1:0] key_ptr;
    logic           hunt_dead;

    assign strb_raw = '{cs_n: cs_n_i, oe_n: oe_n_i, we_n: we_n_i, din: din_i};

    kac_sync #(
        .W       ($bits(strobe_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1110)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (strb_raw),
        .q_o    (strb_sync)
    );

    kac_cycle_det u_cyc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .strb_i (strb_sync),
        .evt_o  (evt)
    );

    kac_seq #(
        .KEY_W      (KEY_W),
        .XFER_W     (XFER_W),
        .KEY        (KEY),
        .RST_EN_BIT (RST_EN_BIT)
    ) u_seq (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .evt_i         (evt),
        .pwr_fail_i    (pwr_fail_i),
        .ext_rst_n_i   (ext_rst_n_i),
        .time_img_i    (time_img_i),
        .xfer_active_o (xfer_active),
        .dout_o        (dout_o),
        .commit_o      (commit_o),
        .commit_data_o (commit_data_o),
        .key_ptr_o     (key_ptr),
        .dead_o        (hunt_dead)
    );

    // gated enable: power-fail level first, then window hold, else pass-through
    always_comb begin
        if (pwr_fail_i) begin
            mem_cs_n_o = !rom_mode_i;
        end else if (xfer_active) begin
            mem_cs_n_o = 1'b1;
        end else begin
            mem_cs_n_o = cs_n_i;
        end
    end

endmodule

// File: rtl/kac_checker.sv
module kac_checker #(
    parameter int unsigned KPW = 6
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           pwr_fail_i,
    input logic           rom_mode_i,
    input logic           ext_rst_n_i,
    input logic           mem_cs_n_o,
    input logic           commit_o,
    input logic           xfer_active,
    input logic           evt_rd,
    input logic           evt_wr,
    input logic [KPW-1:0] key_ptr,
    input logic           dead
);

    assert_window_blocks_mem_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xfer_active && !pwr_fail_i |-> mem_cs_n_o);

    assert_pfail_ram_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_fail_i && !rom_mode_i |-> mem_cs_n_o);

    assert_pfail_rom_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_fail_i && rom_mode_i |-> !mem_cs_n_o);

    assert_pfail_closes_window_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_fail_i |=> !xfer_active && !commit_o);

    assert_commit_at_close_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_o |-> !xfer_active && $past(xfer_active));

    assert_read_clears_ptr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_rd && !xfer_active |=> key_ptr == '0 && !dead);

    assert_dead_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dead && evt_wr && !pwr_fail_i && ext_rst_n_i |=> dead);

    assert_unlock_on_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(xfer_active) |-> $past(evt_wr));

endmodule

bind keyed_access_ctrl kac_checker #(.KPW(KPW)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_fail_i  (pwr_fail_i),
    .rom_mode_i  (rom_mode_i),
    .ext_rst_n_i (ext_rst_n_i),
    .mem_cs_n_o  (mem_cs_n_o),
    .commit_o    (commit_o),
    .xfer_active (xfer_active),
    .evt_rd      (evt.rd),
    .evt_wr      (evt.wr),
    .key_ptr     (key_ptr),
    .dead        (hunt_dead)
);

// File: tb/keyed_access_ctrl_tb_top.sv
`timescale 1ns/1ps
module keyed_access_ctrl_tb_top;

    localparam logic [63:0] IMG_A = 64'h1234_5678_9ABC_DEF0;
    localparam logic [63:0] WPAT  = 64'hA5F0_0FF0_3C96_1E87;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, din = 1'b0;
    logic        pf = 1'b0, rom = 1'b0, ext_n = 1'b1;
    logic [63:0] img = IMG_A;
    logic        mem_cs_n, dout, commit;
    logic [63:0] commit_data;

    always #2.5 clk = ~clk;

    keyed_access_ctrl dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .cs_n_i        (cs_n),
        .oe_n_i        (oe_n),
        .we_n_i        (we_n),
        .din_i         (din),
        .pwr_fail_i    (pf),
        .rom_mode_i    (rom),
        .ext_rst_n_i   (ext_n),
        .time_img_i    (img),
        .mem_cs_n_o    (mem_cs_n),
        .dout_o        (dout),
        .commit_o      (commit),
        .commit_data_o (commit_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit settled  = 1'b0;

    // reference model state
    int          m_st = 0;      // 0 hunting, 1 frozen, 2 window
    int          m_kp = 0;
    int          m_xp = 0;
    logic [63:0] m_sh = '0;
    bit          m_allwr = 1'b0;
    int          m_commits = 0;
    logic [63:0] m_last = '0;

    int          d_commits = 0;
    logic [63:0] d_last = '0;
    logic        cap_mem;

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit key_bit(input int i);
        logic [7:0] kb [4];
        kb = '{8'hC5, 8'h3A, 8'hA3, 8'h5C};
        return kb[(i / 8) % 4][i % 8];
    endfunction

    function automatic void m_abort();
        m_st = 0; m_kp = 0; m_xp = 0; m_allwr = 1'b0;
    endfunction

    // kind: 0 read, 1 write, 2 no strobe, 3 both strobes (counts as write)
    function automatic void m_cycle(input int kind, input bit d);
        bit iswr, isrd;
        iswr = (kind == 1) || (kind == 3);
        isrd = (kind == 0);
        if (pf || !(iswr || isrd)) return;
        case (m_st)
            0: begin
                if (isrd) m_kp = 0;
                else if (d == key_bit(m_kp)) begin
                    if (m_kp == 63) begin
                        m_st = 2; m_kp = 0; m_xp = 0; m_sh = img; m_allwr = 1'b1;
                    end else m_kp++;
                end else m_st = 1;
            end
            1: if (isrd) begin m_st = 0; m_kp = 0; end
            default: begin
                if (iswr) m_sh[m_xp] = d; else m_allwr = 1'b0;
                if (m_xp == 63) begin
                    if (m_allwr) begin m_commits++; m_last = m_sh; end
                    m_abort();
                end else m_xp++;
            end
        endcase
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && settled) begin
            if (pf) chk(mem_cs_n, !rom, "R10");
            else    chk(mem_cs_n, (m_st == 2) ? 1'b1 : cs_n, "R7");
            chk(dout, (m_st == 2) ? m_sh[m_xp] : 1'b0, "R6");
            chk(commit, 1'b0, "R8");
        end
        if (rst_n && commit) begin
            d_commits++;
            d_last = commit_data;
        end
    end

    task automatic bus(input int kind, input bit d);
        @(posedge clk); #1;
        cs_n = 1'b0; din = d;
        oe_n = !(kind == 0 || kind == 3);
        we_n = !(kind == 1 || kind == 3);
        repeat (3) @(posedge clk);
        @(negedge clk);
        cap_mem = mem_cs_n;
        if (pf) chk(mem_cs_n, !rom, "R10");
        else begin
            chk(mem_cs_n, (m_st == 2) ? 1'b1 : 1'b0, "R7");
            if (kind == 0 && m_st == 2) chk(dout, m_sh[m_xp], "R6");
        end
        @(posedge clk); #1;
        settled = 1'b0;
        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        m_cycle(kind, d);
        repeat (6) @(posedge clk); #1;
        settled = 1'b1;
    endtask

    task automatic send_key(input int from, input int upto, input int flip);
        for (int i = from; i < upto; i++) bus(1, key_bit(i) ^ (i == flip));
    endtask

    // a read reveals the lock state via the gated enable, then any window is drained
    task automatic expect_window(input bit exp, input string req);
        bus(0, 1'b0);
        chk(cap_mem, exp, req);
        while (m_st == 2) bus(0, 1'b0);
    endtask

    task automatic set_pf(input bit v);
        @(posedge clk); #1;
        settled = 1'b0; pf = v;
        if (v) m_abort();
        repeat (3) @(posedge clk); #1;
        settled = 1'b1;
    endtask

    task automatic pulse_ext();
        @(posedge clk); #1;
        settled = 1'b0; ext_n = 1'b0;
        if (!img[36]) m_abort();
        repeat (2) @(posedge clk); #1;
        ext_n = 1'b1;
        repeat (3) @(posedge clk); #1;
        settled = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        repeat (5) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(mem_cs_n, 1'b1, "R1");
        chk(commit, 1'b0, "R1");
        chk(dout, 1'b0, "R1");
        settled = 1'b1;
        expect_window(1'b0, "R1");

        // R2, R6, R7: unlock then read the whole image
        send_key(0, 64, -1);
        expect_window(1'b1, "R2");

        // R8, R12: full write window commits; afterwards locked, pointer at 0
        send_key(0, 64, -1);
        for (int i = 0; i < 64; i++) bus(1, WPAT[i]);
        chk(d_commits, m_commits, "R8");
        chk(d_last, WPAT, "R8");
        expect_window(1'b0, "R12");
        send_key(0, 64, -1);
        expect_window(1'b1, "R12");

        // R3: bad bit freezes; a correct key afterwards is ignored
        send_key(0, 64, 10);
        send_key(0, 64, -1);
        expect_window(1'b0, "R3");
        send_key(0, 64, -1);
        expect_window(1'b1, "R3");

        // R4: read mid-key restarts recognition
        send_key(0, 20, -1);
        bus(0, 1'b0);
        send_key(20, 64, -1);
        expect_window(1'b0, "R4");
        send_key(0, 20, -1);
        bus(0, 1'b0);
        send_key(0, 64, -1);
        expect_window(1'b1, "R4");

        // R5: strobe-less cycle ignored, both strobes count as a write
        send_key(0, 10, -1);
        bus(2, 1'b0);
        for (int i = 10; i < 20; i++) bus(3, key_bit(i));
        send_key(20, 64, -1);
        expect_window(1'b1, "R5");

        // R9, R10: power-fail in RAM mode mid-window
        send_key(0, 64, -1);
        for (int i = 0; i < 30; i++) bus(1, WPAT[i]);
        set_pf(1'b1);
        bus(1, 1'b1);
        bus(0, 1'b0);
        set_pf(1'b0);
        chk(d_commits, m_commits, "R9");
        expect_window(1'b0, "R9");
        // ROM mode: key sent during power-fail is ignored
        rom = 1'b1;
        set_pf(1'b1);
        send_key(0, 64, -1);
        set_pf(1'b0);
        rom = 1'b0;
        expect_window(1'b0, "R9");

        // R11: reset honoured when bit 36 is 0
        img = IMG_A & ~(64'h1 << 36);
        send_key(0, 64, -1);
        for (int i = 0; i < 20; i++) bus(1, WPAT[i]);
        pulse_ext();
        chk(d_commits, m_commits, "R11");
        expect_window(1'b0, "R11");
        // R11: reset ignored when bit 36 is 1
        img = IMG_A;
        send_key(0, 64, -1);
        for (int i = 0; i < 20; i++) bus(1, ~WPAT[i]);
        pulse_ext();
        for (int i = 20; i < 64; i++) bus(1, ~WPAT[i]);
        chk(d_commits, m_commits, "R11");
        chk(d_last, ~WPAT, "R11");

        // R8: mixed window closes without commit
        send_key(0, 64, -1);
        for (int i = 0; i < 32; i++) bus(1, WPAT[i]);
        for (int i = 32; i < 64; i++) bus(0, 1'b0);
        chk(d_commits, m_commits, "R8");
        expect_window(1'b0, "R12");

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule